// File: doc/BRIEF.md
# Pixel Cell Hit Capture and Token Readout

This block is the digital part of a single pixel in a sparsified detector array. The array works in two phases. In the detection phase, the cell watches its discriminator output. On the first pulse it sets a hit flag. At that same edge it stops copying the shared timestamp counter, so the counter value at the moment of the hit is kept.

In the readout phase, a single token travels along a chain of cells. A cell with no hit passes the token straight through, with no register in the path. A hit cell blocks the token and captures it at the next clock edge. While it holds the token, it raises its column and row select lines and drives its kept timestamp onto the shared output. When the periphery pulses the advance strobe, the cell drops its hit and its hold. After that it is transparent, and the token moves on.

The timestamp output follows a mux-based model: it is zero whenever the cell does not hold the token, so outputs from many cells can be OR-combined.

Top module: `pixel_cell_digital`

## Requirements
- R1: While `rst_n` is low, and right after it rises, the cell holds no hit and no token: `get_x`, `get_y` are 0, `ts_out` is 0, and in readout `tok_out` equals `tok_in`.
- R2: With `readout` low, a high `hit_in` at a rising clock edge sets the hit flag. Its effect can be seen in the next readout phase.
- R3: The timestamp that is kept is the value of `ts_bus` at the clock edge where the hit is first sampled.
- R4: Only the first hit of a detection phase is recorded. Later hits in the same phase leave the kept timestamp unchanged.
- R5: With `readout` high and no hit, `tok_out` follows `tok_in` in the same cycle, through logic only. With `readout` low, `tok_out` is 0.
- R6: With `readout` high and the hit flag set, `tok_out` is 0. A high `tok_in` is captured at the next edge, and from then on `get_x` and `get_y` are 1.
- R7: `ts_out` carries the kept timestamp only while the token is held. Otherwise it is all zeros.
- R8: `advance` high at an edge while the token is held clears both the hit and the hold. After that edge `tok_out` follows `tok_in` again, and `get_x`, `get_y` and `ts_out` are 0.
- R9: `advance` has no effect while the token is not held. A hit cell that is not holding the token stays hit, and still catches the token later with its kept timestamp.
- R10: `hit_in` has no effect while `readout` is high. This includes the edge at which the cell is released by `advance`.
- R11: When `readout` falls, the token hold is dropped and the hit flag is kept. In the next readout phase the cell catches the token again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Cell clock |
| rst_n | input | 1 | Master reset, active low, asynchronous |
| readout | input | 1 | Phase select: 0 detection, 1 readout |
| hit_in | input | 1 | Discriminator pulse |
| ts_bus | input | TS_W | Shared free-running timestamp counter |
| tok_in | input | 1 | Token from the previous cell |
| advance | input | 1 | Strobe from the periphery: data taken, release token |
| tok_out | output | 1 | Token to the next cell |
| get_x | output | 1 | Column select toward the periphery |
| get_y | output | 1 | Row select toward the periphery |
| ts_out | output | TS_W | Kept timestamp while holding the token, else zero |

## Verification
The release by `advance` and a new discriminator pulse can arrive in the same cycle. If that pulse were taken, the cell would re-arm itself right after being serviced and would block the chain again. The bench provokes this in every sweep case by raising `hit_in` together with `advance` on the releasing edge. It then judges the result by checking that the token passes through combinationally at once, and that the select lines and timestamp stay quiet. The sweep also moves the hit across every counter value, so the kept timestamp can be compared with the hit cycle.

// File: rtl/pixel_cell_digital.sv
module pixel_cell_digital #(
  parameter int TS_W = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            readout,
  input  logic            hit_in,
  input  logic [TS_W-1:0] ts_bus,
  input  logic            tok_in,
  input  logic            advance,
  output logic            tok_out,
  output logic            get_x,
  output logic            get_y,
  output logic [TS_W-1:0] ts_out
);

  logic            hit_q;
  logic            held_q;
  logic [TS_W-1:0] ts_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_q  <= 1'b0;
      held_q <= 1'b0;
      ts_q   <= '0;
    end else begin
      if (!readout && hit_in)
        hit_q <= 1'b1;
      else if (readout && held_q && advance)
        hit_q <= 1'b0;
      if (!hit_q)
        ts_q <= ts_bus;
      held_q <= readout && hit_q && (held_q ? !advance : tok_in);
    end
  end

  assign tok_out = readout & ~hit_q & tok_in;
  assign get_x   = held_q;
  assign get_y   = held_q;
  assign ts_out  = held_q ? ts_q : '0;

  AST_TS_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(hit_q) && hit_q) |-> (ts_q == $past(ts_q))); // R4
  AST_CATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (readout && hit_q && !held_q && tok_in) |=> held_q); // R6
  AST_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (readout && held_q && advance) |=> (!hit_q && !held_q)); // R8
  AST_NO_REARM: assert property (@(posedge clk) disable iff (!rst_n)
    (readout && !hit_q) |=> !hit_q); // R10
  AST_QUIET_AFTER: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(held_q) |-> (ts_out == '0 && !get_x)); // R7
  AST_PHASE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    !readout |=> !held_q); // R11

endmodule

// File: tb/tb_pixel_cell_digital.sv
module tb_pixel_cell_digital;
  localparam int TS_W = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic readout = 1'b0, hit_in = 1'b0, tok_in = 1'b0, advance = 1'b0;
  logic [TS_W-1:0] ts_bus = '0;
  logic tok_out, get_x, get_y;
  logic [TS_W-1:0] ts_out;

  int total = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pixel_cell_digital #(.TS_W(TS_W)) dut (
    .clk(clk), .rst_n(rst_n), .readout(readout), .hit_in(hit_in),
    .ts_bus(ts_bus), .tok_in(tok_in), .advance(advance),
    .tok_out(tok_out), .get_x(get_x), .get_y(get_y), .ts_out(ts_out));

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic settle();
    #1;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; readout = 1'b0; hit_in = 1'b0; tok_in = 1'b0; advance = 1'b0;
    tick();
    chk("R1 get_x in reset", get_x, 0);
    chk("R1 ts_out in reset", ts_out, 0);
    rst_n = 1'b1;
    settle();
  endtask

  task automatic run_case(input int hit_at, input bit second, input bit phase_drop);
    int exp_ts;
    do_reset();
    for (int c = 0; c < 40; c++) begin
      ts_bus = TS_W'(c);
      hit_in = (c == hit_at) || (second && c == hit_at + 3);
      tok_in = c[0];
      settle();
      if (c == 5) chk("R5 no token in detection", tok_out, 0);
      tick();
    end
    hit_in = 1'b0;
    exp_ts = hit_at % 32;
    readout = 1'b1; tok_in = 1'b0;
    settle();
    chk("R7 ts_out idle", ts_out, 0);
    chk("R6 get_y idle", get_y, 0);
    advance = 1'b1;
    tick();
    advance = 1'b0;
    chk("R9 advance without token keeps hit", get_x, 0);
    tok_in = 1'b1;
    settle();
    chk("R2 R6 token blocked", tok_out, 0);
    tick();
    chk("R6 get_x held", get_x, 1);
    chk("R6 get_y held", get_y, 1);
    chk("R3 R4 R9 kept timestamp", ts_out, exp_ts);
    chk("R6 token still blocked", tok_out, 0);
    if (phase_drop) begin
      readout = 1'b0;
      tick();
      chk("R11 hold dropped", get_x, 0);
      readout = 1'b1;
      settle();
      chk("R11 hit kept, token blocked", tok_out, 0);
      tick();
      chk("R11 token caught again", ts_out, exp_ts);
    end
    hit_in = 1'b1;
    tick();
    chk("R10 hit in readout, still held", get_x, 1);
    advance = 1'b1;
    tick();
    advance = 1'b0;
    hit_in = 1'b0;
    settle();
    chk("R8 R10 token passes after release", tok_out, 1);
    chk("R8 get_x released", get_x, 0);
    chk("R8 R7 ts_out released", ts_out, 0);
    tok_in = 1'b0;
    settle();
    chk("R5 pass low", tok_out, 0);
    tick();
    chk("R10 not rearmed", get_y, 0);
    readout = 1'b0;
  endtask

  initial begin
    do_reset();
    readout = 1'b1; tok_in = 1'b1;
    settle();
    chk("R1 token passes after reset", tok_out, 1);
    tok_in = 1'b0;
    settle();
    chk("R5 pass low after reset", tok_out, 0);
    for (int h = 0; h < 32; h++)
      run_case(h, h[0], ~h[0]);
    do_reset();
    for (int c = 0; c < 10; c++) begin
      ts_bus = TS_W'(c);
      tick();
    end
    readout = 1'b1; tok_in = 1'b1;
    settle();
    chk("R5 unhit cell passes", tok_out, 1);
    tick();
    chk("R5 unhit cell no select", get_x, 0);
    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule